// File: doc/BRIEF.md
# T1 Facility Data Link Receive Extractor

This block sits behind a T1 receive framer and gathers the data-link bits of an extended superframe (ESF), or the Fs terminal framing bits of a D4 superframe, into a byte. The framer gives one strobe per frame, along with the recovered framing-bit value, the 1-based frame number within the multiframe and the framing mode. The block picks out the frames that carry the wanted bit and places each bit into an assembly register, least-significant bit first.

When a byte is complete it moves into a host-visible holding register in one step and sets a latched full flag. If the interrupt enable is high, the flag also pulls an active-low interrupt low. In ESF a byte completes on every eighth data-link bit, which at the line rate is once every 2 ms. The host has that long to read it before the next byte replaces it. In D4 the six Fs bits of a superframe are gathered, and the holding register changes only at the superframe boundary, with the two upper bits read as zero. The bits go through untouched: there is no destuffing and no message decoding.

Top module: `t1dl_rx`

## Requirements
- R1: In ESF (`mode_esf_i`=1) a bit is taken only on strobes whose frame number is odd and within 1..23. Strobes for even frames leave the holding register and flag unchanged.
- R2: Bits are packed least-significant first. The first ESF bit taken after a byte boundary lands in bit 0 and the eighth in bit 7. The cycle after the eighth bit's strobe, all eight bits appear on `rx_byte_o` together.
- R3: `full_o` goes to 1 the cycle after a byte completes and stays at 1 until the host clears it.
- R4: `irq_no` is 0 exactly when `full_o` is 1 and `irq_en_i` is 1; otherwise it is 1.
- R5: There is no destuffing. Any bit sequence, including runs of eight ones or eight zeros, arrives in the byte unchanged.
- R6: In D4 (`mode_esf_i`=0) the bit from even frame 2k (k=1..6) goes to bit k-1. The holding register changes only the cycle after the strobe for frame 12. Bits 7:6 read 0, and a bit whose frame was not seen in that superframe reads 0.
- R7: A completed byte overwrites an unread one, and `full_o` stays at 1.
- R8: A one-cycle pulse on `clr_full_i` clears `full_o` on the next cycle. If a byte completes in the same cycle, `full_o` stays at 1.
- R9: A change of `mode_esf_i` throws away all partly assembled bits. The next byte starts again at bit 0.
- R10: While reset is held, `rx_byte_o` is 0x00, `full_o` is 0 and `irq_no` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| frm_stb_i | input | 1 | One-cycle strobe per received frame |
| frm_num_i | input | 5 | Frame number in the multiframe, 1-based (1..24 ESF, 1..12 D4) |
| mode_esf_i | input | 1 | 1 = ESF, 0 = D4 |
| fbit_i | input | 1 | Recovered framing-bit value for the strobed frame |
| clr_full_i | input | 1 | Host write-one-to-clear of the full flag |
| irq_en_i | input | 1 | Interrupt enable (mask) for the full flag |
| rx_byte_o | output | 8 | Holding register read by the host |
| full_o | output | 1 | Latched byte-full status |
| irq_no | output | 1 | Active-low interrupt |

## Verification
A bit counter that slips, or a frame-selection slip, shows on the very next completed byte. That byte has its bits rotated, or it completes one strobe early or late, so `rx_byte_o` and `full_o` differ from the reference at a single cycle within one multiframe. Assembly state that is stale after a mode change shows first on the D4 superframe boundary, or on the first ESF byte after the change. A flag whose set and clear priority is wrong shows in the cycle right after a clear that lands on a commit, and shows on `irq_no` at the same time.

// File: rtl/t1dl_pkg.sv
package t1dl_pkg;
  typedef enum logic {
    FMT_D4  = 1'b0,
    FMT_ESF = 1'b1
  } fmt_e;
endpackage

// File: rtl/t1dl_slot_sel.sv
module t1dl_slot_sel #(
  parameter int IDX_W      = 5,
  parameter int CNT_W      = 3,
  parameter int BYTE_W     = 8,
  parameter int ESF_FRAMES = 24,
  parameter int D4_FRAMES  = 12
) (
  input  logic             stb_i,
  input  t1dl_pkg::fmt_e   fmt_i,
  input  logic [IDX_W-1:0] num_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             take_o,
  output logic             commit_o,
  output logic [CNT_W-1:0] pos_o
);
  localparam logic [IDX_W-1:0] ESF_LAST = IDX_W'(ESF_FRAMES - 1);
  localparam logic [IDX_W-1:0] D4_LAST  = IDX_W'(D4_FRAMES);
  localparam logic [CNT_W-1:0] CNT_TOP  = CNT_W'(BYTE_W - 1);

  logic [IDX_W-2:0] half;

  always_comb begin
    half     = num_i[IDX_W-1:1] - 1'b1;
    take_o   = 1'b0;
    commit_o = 1'b0;
    pos_o    = cnt_i;
    if (fmt_i == t1dl_pkg::FMT_ESF) begin
      take_o   = stb_i && num_i[0] && (num_i <= ESF_LAST);
      commit_o = take_o && (cnt_i == CNT_TOP);
    end else begin
      take_o   = stb_i && !num_i[0] && (num_i != '0) && (num_i <= D4_LAST);
      pos_o    = half[CNT_W-1:0];
      commit_o = take_o && (num_i == D4_LAST);
    end
  end
endmodule

// File: rtl/t1dl_assembler.sv
module t1dl_assembler #(
  parameter int BYTE_W  = 8,
  parameter int CNT_W   = 3,
  parameter int D4_BITS = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  t1dl_pkg::fmt_e    fmt_i,
  input  logic              take_i,
  input  logic              commit_i,
  input  logic [CNT_W-1:0]  pos_i,
  input  logic              bit_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [BYTE_W-1:0] word_o
);
  localparam logic [BYTE_W-1:0] D4_MASK =
    {{(BYTE_W-D4_BITS){1'b0}}, {D4_BITS{1'b1}}};
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(BYTE_W - 1);

  logic [BYTE_W-1:0] asm_q, asm_d, base;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  t1dl_pkg::fmt_e    fmt_q;
  logic              restart;

  always_comb begin
    restart = (fmt_q != fmt_i);
    base    = restart ? '0 : asm_q;
    cnt_o   = restart ? '0 : cnt_q;
    word_o  = base;
    if (take_i) word_o[pos_i] = bit_i;
    if (fmt_i == t1dl_pkg::FMT_D4) word_o = word_o & D4_MASK;
    asm_d = base;
    cnt_d = cnt_o;
    if (take_i) begin
      asm_d = word_o;
      if (fmt_i == t1dl_pkg::FMT_ESF)
        cnt_d = (cnt_o == CNT_TOP) ? '0 : cnt_o + 1'b1;
    end
    if (commit_i) asm_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      asm_q <= '0;
      cnt_q <= '0;
      fmt_q <= t1dl_pkg::FMT_ESF;
    end else begin
      asm_q <= asm_d;
      cnt_q <= cnt_d;
      fmt_q <= fmt_i;
    end
  end
endmodule

// File: rtl/t1dl_hold.sv
module t1dl_hold #(
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              commit_i,
  input  logic [BYTE_W-1:0] word_i,
  input  logic              clr_i,
  input  logic              irq_en_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              full_o,
  output logic              irq_no
);
  logic [BYTE_W-1:0] byte_q, byte_d;
  logic              full_q, full_d;
  logic              byte_en;

  always_comb begin
    byte_en = commit_i;
    byte_d  = word_i;
    full_d  = full_q;
    if (commit_i)   full_d = 1'b1;
    else if (clr_i) full_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byte_q <= '0;
      full_q <= 1'b0;
    end else begin
      if (byte_en) byte_q <= byte_d;
      full_q <= full_d;
    end
  end

  assign byte_o = byte_q;
  assign full_o = full_q;
  assign irq_no = ~(full_q & irq_en_i);
endmodule

// File: rtl/t1dl_rx.sv
module t1dl_rx #(
  parameter int BYTE_W     = 8,
  parameter int ESF_FRAMES = 24,
  parameter int D4_FRAMES  = 12,
  parameter int IDX_W      = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frm_stb_i,
  input  logic [IDX_W-1:0]  frm_num_i,
  input  logic              mode_esf_i,
  input  logic              fbit_i,
  input  logic              clr_full_i,
  input  logic              irq_en_i,
  output logic [BYTE_W-1:0] rx_byte_o,
  output logic              full_o,
  output logic              irq_no
);
  localparam int CNT_W   = $clog2(BYTE_W);
  localparam int D4_BITS = D4_FRAMES / 2;

  logic [1:0]        rst_sync_q;
  logic              rst_n_int;
  t1dl_pkg::fmt_e    fmt;
  logic              take, commit;
  logic [CNT_W-1:0]  pos, cnt;
  logic [BYTE_W-1:0] word;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];
  assign fmt = mode_esf_i ? t1dl_pkg::FMT_ESF : t1dl_pkg::FMT_D4;

  t1dl_slot_sel #(
    .IDX_W(IDX_W), .CNT_W(CNT_W), .BYTE_W(BYTE_W),
    .ESF_FRAMES(ESF_FRAMES), .D4_FRAMES(D4_FRAMES)
  ) u_sel (
    .stb_i(frm_stb_i & rst_n_int), .fmt_i(fmt), .num_i(frm_num_i),
    .cnt_i(cnt), .take_o(take), .commit_o(commit), .pos_o(pos)
  );

  t1dl_assembler #(
    .BYTE_W(BYTE_W), .CNT_W(CNT_W), .D4_BITS(D4_BITS)
  ) u_asm (
    .clk_i(clk_i), .rst_ni(rst_n_int), .fmt_i(fmt), .take_i(take),
    .commit_i(commit), .pos_i(pos), .bit_i(fbit_i),
    .cnt_o(cnt), .word_o(word)
  );

  t1dl_hold #(.BYTE_W(BYTE_W)) u_hold (
    .clk_i(clk_i), .rst_ni(rst_n_int), .commit_i(commit), .word_i(word),
    .clr_i(clr_full_i), .irq_en_i(irq_en_i),
    .byte_o(rx_byte_o), .full_o(full_o), .irq_no(irq_no)
  );
endmodule

// File: rtl/t1dl_rx_chk.sv
module t1dl_rx_chk #(
  parameter int BYTE_W    = 8,
  parameter int D4_FRAMES = 12,
  parameter int IDX_W     = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              frm_stb_i,
  input logic [IDX_W-1:0]  frm_num_i,
  input logic              mode_esf_i,
  input logic              clr_full_i,
  input logic              irq_en_i,
  input logic [BYTE_W-1:0] rx_byte_o,
  input logic              full_o,
  input logic              irq_no
);
  localparam int D4_BITS = D4_FRAMES / 2;

  // R3
  full_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(full_o) |-> $past(frm_stb_i));

  // R4
  irq_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_no |-> (full_o && irq_en_i));

  // R6
  d4_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rx_byte_o) |->
      ($past(frm_stb_i) && ($past(mode_esf_i) || $past(frm_num_i) == IDX_W'(D4_FRAMES))));

  // R6
  d4_top_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(frm_stb_i) && !$past(mode_esf_i) && !$stable(rx_byte_o))
      |-> (rx_byte_o[BYTE_W-1:D4_BITS] == '0));

  // R8
  clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(clr_full_i && !frm_stb_i) |-> !full_o);

  // R1
  esf_even_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(frm_stb_i && mode_esf_i && !frm_num_i[0]) |-> $stable(rx_byte_o));
endmodule

bind t1dl_rx t1dl_rx_chk #(
  .BYTE_W(BYTE_W), .D4_FRAMES(D4_FRAMES), .IDX_W(IDX_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .frm_stb_i(frm_stb_i), .frm_num_i(frm_num_i),
  .mode_esf_i(mode_esf_i), .clr_full_i(clr_full_i), .irq_en_i(irq_en_i),
  .rx_byte_o(rx_byte_o), .full_o(full_o), .irq_no(irq_no)
);

// File: tb/t1dl_rx_tb.sv
module t1dl_rx_tb;
  logic       clk = 1'b0;
  logic       rst_ni;
  logic       frm_stb_i, mode_esf_i, fbit_i, clr_full_i, irq_en_i;
  logic [4:0] frm_num_i;
  logic [7:0] rx_byte_o;
  logic       full_o, irq_no;

  int n_chk = 0, n_fail = 0;
  int fnum = 1;

  // reference model state
  bit   q[$];
  bit   d4v[6];
  logic [7:0] m_byte = 8'h00;
  logic       m_full = 1'b0;
  logic       m_mode = 1'b1;

  always #2 clk = ~clk;

  t1dl_rx u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .frm_stb_i(frm_stb_i), .frm_num_i(frm_num_i),
    .mode_esf_i(mode_esf_i), .fbit_i(fbit_i), .clr_full_i(clr_full_i),
    .irq_en_i(irq_en_i), .rx_byte_o(rx_byte_o), .full_o(full_o), .irq_no(irq_no)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model(input logic stb, input int num, input logic b, input logic clr);
    logic       done = 1'b0;
    logic [7:0] v = 8'h00;
    if (mode_esf_i != m_mode) begin
      q.delete();
      foreach (d4v[i]) d4v[i] = 1'b0;
    end
    m_mode = mode_esf_i;
    if (stb && mode_esf_i && (num % 2 == 1) && num <= 23) begin
      q.push_back(b);
      if (q.size() == 8) begin
        foreach (q[i]) v[i] = q[i];
        q.delete();
        done = 1'b1;
      end
    end
    if (stb && !mode_esf_i && (num % 2 == 0) && num >= 2 && num <= 12) begin
      d4v[num/2-1] = b;
      if (num == 12) begin
        foreach (d4v[i]) begin v[i] = d4v[i]; d4v[i] = 1'b0; end
        done = 1'b1;
      end
    end
    if (done) begin m_byte = v; m_full = 1'b1; end
    else if (clr) m_full = 1'b0;
  endtask

  task automatic step(input logic stb, input int num, input logic b, input logic clr);
    @(negedge clk);
    chk(mode_esf_i ? "R2" : "R6", rx_byte_o, m_byte);
    chk("R3", full_o, m_full);
    chk("R4", irq_no, !(m_full && irq_en_i));
    frm_stb_i  = stb;
    frm_num_i  = 5'(num);
    fbit_i     = b;
    clr_full_i = clr;
    model(stb, num, b, clr);
  endtask

  task automatic next_frame(input logic b, input logic clr);
    step(1'b1, fnum, b, clr);
    step(1'b0, 0, 1'b0, 1'b0);
    step(1'b0, 0, 1'b0, 1'b0);
    fnum = (fnum == (mode_esf_i ? 24 : 12)) ? 1 : fnum + 1;
  endtask

  task automatic esf_byte(input logic [7:0] v, input logic clr_last);
    for (int i = 0; i < 8; i++) begin
      while (fnum % 2 == 0) next_frame(1'($urandom), 1'b0);
      next_frame(v[i], (i == 7) ? clr_last : 1'b0);
    end
  endtask

  task automatic d4_super(input logic [5:0] v);
    fnum = 1;
    for (int f = 1; f <= 12; f++)
      next_frame((f % 2 == 0) ? v[f/2-1] : 1'($urandom), 1'b0);
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; frm_stb_i = 1'b0; frm_num_i = '0; mode_esf_i = 1'b1;
    fbit_i = 1'b0; clr_full_i = 1'b0; irq_en_i = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10", rx_byte_o, 8'h00);
    chk("R10", full_o, 1'b0);
    chk("R10", irq_no, 1'b1);
    rst_ni = 1'b1;
    repeat (4) step(1'b0, 0, 1'b0, 1'b0);

    fnum = 1;
    esf_byte(8'hA5, 1'b0);
    chk("R2", rx_byte_o, 8'hA5);
    chk("R3", full_o, 1'b1);
    chk("R4", irq_no, 1'b0);
    step(1'b0, 0, 1'b0, 1'b1);
    step(1'b0, 0, 1'b0, 1'b0);
    chk("R8", full_o, 1'b0);
    chk("R4", irq_no, 1'b1);

    esf_byte(8'hFF, 1'b0);
    chk("R5", rx_byte_o, 8'hFF);
    esf_byte(8'h00, 1'b0);
    chk("R7", rx_byte_o, 8'h00);
    chk("R7", full_o, 1'b1);
    irq_en_i = 1'b0;
    step(1'b0, 0, 1'b0, 1'b0);
    chk("R4", irq_no, 1'b1);
    irq_en_i = 1'b1;

    // even ESF frames only: nothing captured
    for (int k = 0; k < 5; k++) begin
      step(1'b1, 2 * k + 2, 1'b1, 1'b0);
      step(1'b0, 0, 1'b0, 1'b0);
    end
    chk("R1", rx_byte_o, 8'h00);

    // clear coinciding with the completing bit
    esf_byte(8'h3C, 1'b1);
    chk("R8", full_o, 1'b1);
    chk("R2", rx_byte_o, 8'h3C);

    // partial ESF byte, then D4, then back to ESF
    step(1'b0, 0, 1'b0, 1'b1);
    for (int k = 0; k < 3; k++) begin
      while (fnum % 2 == 0) next_frame(1'b1, 1'b0);
      next_frame(1'b1, 1'b0);
    end
    mode_esf_i = 1'b0;
    d4_super(6'b101101);
    chk("R6", rx_byte_o, 8'h2D);
    chk("R9", full_o, 1'b1);
    mode_esf_i = 1'b1;
    fnum = 1;
    esf_byte(8'hC3, 1'b0);
    chk("R9", rx_byte_o, 8'hC3);

    // mixed random traffic
    for (int r = 0; r < 30; r++) begin
      esf_byte(8'($urandom), 1'($urandom));
      if (r % 3 == 0) step(1'b0, 0, 1'b0, 1'b1);
      if (r % 7 == 0) irq_en_i = ~irq_en_i;
    end
    mode_esf_i = 1'b0;
    for (int r = 0; r < 8; r++) begin
      d4_super(6'($urandom));
      step(1'b0, 0, 1'b0, 1'($urandom));
    end
    step(1'b0, 0, 1'b0, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule